// File: doc/BRIEF.md
# SPI Interrupt and DMA Request Logic

This block is the event and request stage of a four-channel SPI controller. It keeps an interrupt status register and an interrupt enable register. From the state of each channel it builds one interrupt line and a transmit and a receive DMA request line for every channel. Each channel's state comes in as a set of inputs: the enable, the TX-empty and RX-full flags, the transfer mode, and the DMA enables. The block also takes the level and threshold of the one FIFO pair that a single channel may own, and a word counter whose expiry raises a separate event. Shifting and FIFO storage are outside the block. It only observes levels, pushes and pops.

Software clears status bits by writing ones. It loads the enable register with a plain write. A test mode sets every implemented status bit at once. While that mode is active, clear writes have no effect, so the forced pattern stays in place for as long as the mode holds. The DMA request lines are registered and follow their qualifying inputs one cycle later.

Top module: `spi_irq_dma`

## Requirements
- R1: `irq` is high exactly when some bit is set in both `irqStatus` and `irqEnable`. It follows those registers in the same cycle.
- R2: A write with `wrSel`=1 loads `irqEnable` with `wrData` ANDed with the implemented-bit mask 0x3777F, visible after the next clock edge.
- R3: Status bit 4n (channel n TX empty) sets when `chEnable[n]`, `txEmpty[n]`, the mode of channel n (`trMode[2n+1:2n]`) is not receive-only (2'b01), and the TX FIFO gate is open. The TX gate is open when channel n is not `fifoOwner` with `txFifoOn`, or when `txLevel` <= `almostEmpty`. Set bits stay set until cleared.
- R4: Status bit 4n+2 (channel n RX full) sets when `chEnable[n]`, `rxFull[n]`, the mode is not transmit-only (2'b10), and the RX FIFO gate is open. The RX gate is open when channel n is not `fifoOwner` with `rxFifoOn`, or when `rxLevel` >= `almostFull`.
- R5: A write with `wrSel`=0 clears every status bit written as one. A bit that is set by an event in the same cycle stays set.
- R6: While `sysTestMode` and `testSet` are both high, all status bits in 0x3777F are forced set each cycle, and status clear writes have no effect.
- R7: Status bit 17 (word count done) sets when `wordLimit` is nonzero and `wordsLeft` is zero.
- R8: `txReq[n]` one cycle later equals the R3 condition for channel n ANDed with `txDmaEn[n]`. `rxReq[n]` one cycle later equals the R4 condition ANDed with `rxDmaEn[n]`.
- R9: A `txPush` forces `txReq` of the `fifoOwner` channel low in the following cycle. An `rxPop` does the same for `rxReq`.
- R10: After reset, status, enable, `irq` and all request lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 status (clear by ones), 1 enable |
| wrData | input | 18 | Write data |
| sysTestMode | input | 1 | System test mode |
| testSet | input | 1 | Test set bit |
| chEnable | input | 4 | Channel enables |
| txDmaEn | input | 4 | Transmit DMA enables |
| rxDmaEn | input | 4 | Receive DMA enables |
| trMode | input | 8 | Two-bit transfer mode per channel (01 receive-only, 10 transmit-only) |
| txEmpty | input | 4 | Channel TX-empty flags |
| rxFull | input | 4 | Channel RX-full flags |
| fifoOwner | input | 2 | Channel that owns the FIFO pair |
| txFifoOn | input | 1 | TX FIFO in use |
| rxFifoOn | input | 1 | RX FIFO in use |
| txLevel | input | 7 | TX FIFO fill level |
| rxLevel | input | 7 | RX FIFO fill level |
| almostEmpty | input | 6 | TX threshold |
| almostFull | input | 6 | RX threshold |
| txPush | input | 1 | TX FIFO push this cycle |
| rxPop | input | 1 | RX FIFO pop this cycle |
| wordLimit | input | 16 | Programmed word count (0 = off) |
| wordsLeft | input | 16 | Words remaining |
| irq | output | 1 | Interrupt line |
| txReq | output | 4 | Transmit DMA requests |
| rxReq | output | 4 | Receive DMA requests |
| irqStatus | output | 18 | Status register |
| irqEnable | output | 18 | Enable register |

## Verification
Random cycles vary the channel flags, modes, DMA enables, FIFO ownership, levels and thresholds together. These patterns separate the effect of each gate term on status bits and request lines. Directed cycles put the FIFO levels exactly on and one step past the thresholds, which exposes off-by-one comparisons. Other directed cycles issue a clear in the same cycle as a set event, which shows whether set wins over clear. Further directed cycles hold the test lock with clears pending, and push or pop on an otherwise requesting owner channel, which isolates the lock and the drop terms from the rest of the logic.

// File: rtl/spi_irq_dma_pkg.sv
package spi_irq_dma_pkg;
  localparam int NCH    = 4;
  localparam int STW    = 4 * NCH + 2;
  localparam int EOWBIT = 4 * NCH + 1;

  localparam logic [1:0] MODE_RX_ONLY = 2'b01;
  localparam logic [1:0] MODE_TX_ONLY = 2'b10;

  typedef struct packed {
    logic [STW-1:0] clrMask;
    logic           enLoad;
    logic [STW-1:0] enData;
    logic           forceAll;
    logic [STW-1:0] setVec;
    logic [NCH-1:0] txQual;
    logic [NCH-1:0] rxQual;
  } strobe_t;

  function automatic logic [STW-1:0] implMask();
    logic [STW-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[4*c]   = 1'b1;
      m[4*c+1] = 1'b1;
      m[4*c+2] = 1'b1;
    end
    m[3]        = 1'b1;
    m[4*NCH]    = 1'b1;
    m[4*NCH+1]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/spi_irq_dma_ctrl.sv
module spi_irq_dma_ctrl
  import spi_irq_dma_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int THR_W  = 6,
  parameter int WCNT_W = 16,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [STW-1:0]    wrData,
  input  logic              sysTestMode,
  input  logic              testSet,
  input  logic [NCH-1:0]    chEnable,
  input  logic [NCH-1:0]    txDmaEn,
  input  logic [NCH-1:0]    rxDmaEn,
  input  logic [2*NCH-1:0]  trMode,
  input  logic [NCH-1:0]    txEmpty,
  input  logic [NCH-1:0]    rxFull,
  input  logic [CH_W-1:0]   fifoOwner,
  input  logic              txFifoOn,
  input  logic              rxFifoOn,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [THR_W-1:0]  almostEmpty,
  input  logic [THR_W-1:0]  almostFull,
  input  logic              txPush,
  input  logic              rxPop,
  input  logic [WCNT_W-1:0] wordLimit,
  input  logic [WCNT_W-1:0] wordsLeft,
  output strobe_t           strb
);
  localparam logic [STW-1:0] MASK = implMask();

  logic           testLock;
  logic [NCH-1:0] txSet;
  logic [NCH-1:0] rxSet;
  logic [NCH-1:0] txQualVec;
  logic [NCH-1:0] rxQualVec;
  logic           eowHit;

  assign testLock = sysTestMode & testSet;
  assign eowHit   = (wordLimit != '0) && (wordsLeft == '0);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic isOwner;
    logic txGate;
    logic rxGate;
    logic [1:0] mode;
    assign mode    = trMode[2*ch +: 2];
    assign isOwner = (fifoOwner == CH_W'(ch));
    assign txGate  = !(isOwner && txFifoOn) || (txLevel <= LVL_W'(almostEmpty));
    assign rxGate  = !(isOwner && rxFifoOn) || (rxLevel >= LVL_W'(almostFull));
    assign txSet[ch] = chEnable[ch] & txEmpty[ch] & (mode != MODE_RX_ONLY) & txGate;
    assign rxSet[ch] = chEnable[ch] & rxFull[ch]  & (mode != MODE_TX_ONLY) & rxGate;
    assign txQualVec[ch] = txSet[ch] & txDmaEn[ch] & ~(txPush & isOwner);
    assign rxQualVec[ch] = rxSet[ch] & rxDmaEn[ch] & ~(rxPop & isOwner);
  end

  always_comb begin
    strb          = '0;
    strb.clrMask  = (wrEn && !wrSel && !testLock) ? wrData : '0;
    strb.enLoad   = wrEn && wrSel;
    strb.enData   = wrData & MASK;
    strb.forceAll = testLock;
    for (int c = 0; c < NCH; c++) begin
      strb.setVec[4*c]   = txSet[c];
      strb.setVec[4*c+2] = rxSet[c];
    end
    strb.setVec[EOWBIT] = eowHit;
    strb.txQual = txQualVec;
    strb.rxQual = rxQualVec;
  end
endmodule

// File: rtl/spi_irq_dma_dp.sv
module spi_irq_dma_dp
  import spi_irq_dma_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strb,
  output logic           irq,
  output logic [NCH-1:0] txReq,
  output logic [NCH-1:0] rxReq,
  output logic [STW-1:0] statusQ,
  output logic [STW-1:0] enableQ
);
  localparam logic [STW-1:0] MASK = implMask();

  logic [STW-1:0] statusD;

  always_comb begin
    statusD = (statusQ & ~strb.clrMask) | strb.setVec;
    if (strb.forceAll) statusD = statusD | MASK;
    statusD = statusD & MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      txReq   <= '0;
      rxReq   <= '0;
    end else begin
      statusQ <= statusD;
      if (strb.enLoad) enableQ <= strb.enData;
      txReq <= strb.txQual;
      rxReq <= strb.rxQual;
    end
  end

  assign irq = |(statusQ & enableQ);

  a_r6_force_sets_all: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceAll |=> ((statusQ & MASK) == MASK));

  a_r5_clear_takes_effect: assert property (@(posedge clk) disable iff (!rstN)
    (|(strb.clrMask & ~strb.setVec) && !strb.forceAll)
      |=> ((statusQ & $past(strb.clrMask & ~strb.setVec)) == '0));

  a_r1_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != '0 && enableQ != '0));

  a_r3_set_is_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec != '0) |=> ((statusQ & $past(strb.setVec)) == $past(strb.setVec)));
endmodule

// File: rtl/spi_irq_dma.sv
module spi_irq_dma
  import spi_irq_dma_pkg::*;
#(
  parameter int NUM_CH = NCH,
  parameter int LVL_W  = 7,
  parameter int THR_W  = 6,
  parameter int WCNT_W = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ST_W  = 4 * NUM_CH + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [ST_W-1:0]     wrData,
  input  logic                sysTestMode,
  input  logic                testSet,
  input  logic [NUM_CH-1:0]   chEnable,
  input  logic [NUM_CH-1:0]   txDmaEn,
  input  logic [NUM_CH-1:0]   rxDmaEn,
  input  logic [2*NUM_CH-1:0] trMode,
  input  logic [NUM_CH-1:0]   txEmpty,
  input  logic [NUM_CH-1:0]   rxFull,
  input  logic [CH_W-1:0]     fifoOwner,
  input  logic                txFifoOn,
  input  logic                rxFifoOn,
  input  logic [LVL_W-1:0]    txLevel,
  input  logic [LVL_W-1:0]    rxLevel,
  input  logic [THR_W-1:0]    almostEmpty,
  input  logic [THR_W-1:0]    almostFull,
  input  logic                txPush,
  input  logic                rxPop,
  input  logic [WCNT_W-1:0]   wordLimit,
  input  logic [WCNT_W-1:0]   wordsLeft,
  output logic                irq,
  output logic [NUM_CH-1:0]   txReq,
  output logic [NUM_CH-1:0]   rxReq,
  output logic [ST_W-1:0]     irqStatus,
  output logic [ST_W-1:0]     irqEnable
);
  strobe_t strb;

  spi_irq_dma_ctrl #(
    .LVL_W(LVL_W), .THR_W(THR_W), .WCNT_W(WCNT_W)
  ) u_ctrl (
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .sysTestMode(sysTestMode), .testSet(testSet),
    .chEnable(chEnable), .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn),
    .trMode(trMode), .txEmpty(txEmpty), .rxFull(rxFull),
    .fifoOwner(fifoOwner), .txFifoOn(txFifoOn), .rxFifoOn(rxFifoOn),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .almostEmpty(almostEmpty), .almostFull(almostFull),
    .txPush(txPush), .rxPop(rxPop),
    .wordLimit(wordLimit), .wordsLeft(wordsLeft),
    .strb(strb)
  );

  spi_irq_dma_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .irq(irq), .txReq(txReq), .rxReq(rxReq),
    .statusQ(irqStatus), .enableQ(irqEnable)
  );

  a_r9_tx_push_drops: assert property (@(posedge clk) disable iff (!rstN)
    txPush |=> !txReq[$past(fifoOwner)]);

  a_r9_rx_pop_drops: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> !rxReq[$past(fifoOwner)]);

  a_r7_eow_sets: assert property (@(posedge clk) disable iff (!rstN)
    (wordLimit != '0 && wordsLeft == '0) |=> irqStatus[ST_W-1]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r8_rx_only_blocks_tx: assert property (@(posedge clk) disable iff (!rstN)
      (trMode[2*g +: 2] == MODE_RX_ONLY) |=> !txReq[g]);
    a_r8_tx_only_blocks_rx: assert property (@(posedge clk) disable iff (!rstN)
      (trMode[2*g +: 2] == MODE_TX_ONLY) |=> !rxReq[g]);
  end
endmodule

// File: tb/spi_irq_dma_tb.sv
module spi_irq_dma_tb;
  localparam int NC = 4;
  localparam int SW = 18;
  localparam logic [SW-1:0] MSK = 18'h3777F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrSel = 0;
  logic [SW-1:0] wrData = '0;
  logic sysTestMode = 0, testSet = 0;
  logic [NC-1:0] chEnable = '0, txDmaEn = '0, rxDmaEn = '0, txEmpty = '0, rxFull = '0;
  logic [2*NC-1:0] trMode = '0;
  logic [1:0] fifoOwner = '0;
  logic txFifoOn = 0, rxFifoOn = 0, txPush = 0, rxPop = 0;
  logic [6:0] txLevel = '0, rxLevel = '0;
  logic [5:0] almostEmpty = '0, almostFull = '0;
  logic [15:0] wordLimit = '0, wordsLeft = '0;
  logic irq;
  logic [NC-1:0] txReq, rxReq;
  logic [SW-1:0] irqStatus, irqEnable;

  int checks = 0;
  int fails = 0;
  logic [SW-1:0] expSt = '0, expEn = '0;
  logic [NC-1:0] expTx = '0, expRx = '0;

  always #2 clk = ~clk;

  spi_irq_dma u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .sysTestMode(sysTestMode), .testSet(testSet), .chEnable(chEnable),
    .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn), .trMode(trMode),
    .txEmpty(txEmpty), .rxFull(rxFull), .fifoOwner(fifoOwner),
    .txFifoOn(txFifoOn), .rxFifoOn(rxFifoOn), .txLevel(txLevel),
    .rxLevel(rxLevel), .almostEmpty(almostEmpty), .almostFull(almostFull),
    .txPush(txPush), .rxPop(rxPop), .wordLimit(wordLimit),
    .wordsLeft(wordsLeft), .irq(irq), .txReq(txReq), .rxReq(rxReq),
    .irqStatus(irqStatus), .irqEnable(irqEnable)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected next state from the requirements (R2 to R9).
  task automatic modelStep();
    logic [SW-1:0] setv, clr, nst;
    logic [NC-1:0] nTx, nRx;
    logic lock;
    setv = '0; nTx = '0; nRx = '0;
    lock = sysTestMode && testSet;
    for (int c = 0; c < NC; c++) begin
      logic own, txG, rxG, txC, rxC;
      logic [1:0] m;
      m   = trMode[2*c +: 2];
      own = (int'(fifoOwner) == c);
      txG = !(own && txFifoOn) || (int'(txLevel) <= int'(almostEmpty));
      rxG = !(own && rxFifoOn) || (int'(rxLevel) >= int'(almostFull));
      txC = chEnable[c] && txEmpty[c] && (m != 2'b01) && txG;
      rxC = chEnable[c] && rxFull[c] && (m != 2'b10) && rxG;
      setv[4*c]   = txC;
      setv[4*c+2] = rxC;
      nTx[c] = txC && txDmaEn[c] && !(txPush && own);
      nRx[c] = rxC && rxDmaEn[c] && !(rxPop && own);
    end
    if (wordLimit != 0 && wordsLeft == 0) setv[17] = 1'b1;
    clr = (wrEn && !wrSel && !lock) ? wrData : '0;
    nst = (expSt & ~clr) | setv | (lock ? MSK : '0);
    expSt = nst & MSK;
    if (wrEn && wrSel) expEn = wrData & MSK;
    expTx = nTx;
    expRx = nRx;
  endtask

  task automatic stepCheck();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    cmp("R3 R4 R5 R6 R7 status", 32'(irqStatus), 32'(expSt));
    cmp("R2 enable", 32'(irqEnable), 32'(expEn));
    cmp("R1 irq", 32'(irq), 32'(|(expSt & expEn)));
    cmp("R8 R9 txReq", 32'(txReq), 32'(expTx));
    cmp("R8 R9 rxReq", 32'(rxReq), 32'(expRx));
  endtask

  task automatic quiet();
    wrEn = 0; wrSel = 0; wrData = '0; sysTestMode = 0; testSet = 0;
    chEnable = '0; txDmaEn = '0; rxDmaEn = '0; txEmpty = '0; rxFull = '0;
    trMode = '0; txPush = 0; rxPop = 0; wordLimit = '0; wordsLeft = '0;
    txFifoOn = 0; rxFifoOn = 0;
  endtask

  task automatic randomize_inputs();
    wrEn = ($urandom_range(0, 3) == 0);
    wrSel = $urandom_range(0, 1);
    wrData = SW'($urandom);
    sysTestMode = ($urandom_range(0, 7) == 0);
    testSet = ($urandom_range(0, 3) == 0);
    chEnable = NC'($urandom); txDmaEn = NC'($urandom); rxDmaEn = NC'($urandom);
    txEmpty = NC'($urandom); rxFull = NC'($urandom);
    trMode = 8'($urandom);
    fifoOwner = 2'($urandom);
    txFifoOn = $urandom_range(0, 1); rxFifoOn = $urandom_range(0, 1);
    txLevel = 7'($urandom_range(0, 64)); rxLevel = 7'($urandom_range(0, 64));
    almostEmpty = 6'($urandom); almostFull = 6'($urandom);
    txPush = $urandom_range(0, 1); rxPop = $urandom_range(0, 1);
    wordLimit = ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom_range(1, 9));
    wordsLeft = 16'($urandom_range(0, 2));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    cmp("R10 status", 32'(irqStatus), 0);
    cmp("R10 enable", 32'(irqEnable), 0);
    cmp("R10 irq", 32'(irq), 0);
    cmp("R10 txReq", 32'(txReq), 0);
    cmp("R10 rxReq", 32'(rxReq), 0);
    rstN = 1'b1;

    // R2: enable write masked
    quiet(); wrEn = 1; wrSel = 1; wrData = '1; stepCheck();
    // R3/R4/R8: channel 1 owns FIFOs, level exactly on threshold, then one past
    quiet(); fifoOwner = 2'd1; txFifoOn = 1; rxFifoOn = 1;
    chEnable = 4'b0010; txEmpty = 4'b0010; rxFull = 4'b0010;
    txDmaEn = 4'b0010; rxDmaEn = 4'b0010;
    almostEmpty = 6'd10; txLevel = 7'd10; almostFull = 6'd20; rxLevel = 7'd20;
    stepCheck();
    txLevel = 7'd11; rxLevel = 7'd19; stepCheck();
    // R9: push and pop on a requesting owner channel
    txLevel = 7'd0; rxLevel = 7'd40; txPush = 1; rxPop = 1; stepCheck();
    txPush = 0; rxPop = 0; stepCheck();
    // R5: clear in the same cycle as a set event (set wins), then plain clear
    wrEn = 1; wrSel = 0; wrData = '1; stepCheck();
    quiet(); wrEn = 1; wrSel = 0; wrData = '1; stepCheck();
    // R6: test lock forces status and blocks clears
    quiet(); sysTestMode = 1; testSet = 1; stepCheck();
    wrEn = 1; wrSel = 0; wrData = '1; stepCheck();
    quiet(); testSet = 1; wrEn = 1; wrSel = 0; wrData = '1; stepCheck();
    // R7: word count done
    quiet(); wordLimit = 16'd5; wordsLeft = 16'd0; stepCheck();
    wordsLeft = 16'd1; stepCheck();
    // R3/R8: receive-only and transmit-only modes
    quiet(); chEnable = '1; txEmpty = '1; rxFull = '1; txDmaEn = '1; rxDmaEn = '1;
    trMode = 8'b01_10_01_10; stepCheck();
    trMode = 8'b11_00_11_00; stepCheck();

    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      stepCheck();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule